// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of processor system-control registers reached through a small register port. Each access carries a 4-bit register number, a read or a write strobe, and 32-bit write data. Two side inputs steer it. A 2-bit cache-select value picks which physical bank behind a register number the access reaches. A 3-bit area index picks one of the memory-region entries. The bank holds the constant identification words, control, cache-control, bufferable, protection, region, lockdown and trace-ID storage.

Register 7 has no storage. A write to it is decoded into a one-cycle maintenance command that carries an opcode and an 8-byte-aligned address. The cache logic elsewhere acts on that command. This block performs no maintenance itself.

Each access is sequenced by a three-state machine:
- ST_IDLE: no access in flight.
- ST_DONE: the access was accepted.
- ST_FAULT: the access was refused.

The transitions are the same from every state. A legal request goes to ST_DONE (transition *accept*). An illegal request goes to ST_FAULT (transition *refuse*). No request returns the machine to ST_IDLE (transition *settle*).

Top module: `sysctl_regbank`

## Requirements
- R1: After synchronous active-high reset, `acc_ack`, `acc_err` and `mnt_valid` are 0, and every stored register and region entry reads 0.
- R2: Register 0 is read-only. A read with cache-select 0, 1 or 2 returns the parameters `ID_WORD`, `CACHE_CFG` or `TCM_INFO` respectively. A read with cache-select 3 is an error. Any write to register 0 is an error and changes nothing.
- R3: A request sampled at a rising edge gives `acc_ack`=1 for the following cycle. Read data is valid in that same cycle. Raising both strobes together is an error with no effect.
- R4: Registers 1, 3 and 13 each hold a full 32-bit word and ignore cache-select.
- R5: Register 2 reaches the data-cache control word when cache-select is 0 or 2. It reaches the instruction-cache control word when cache-select is 1 or 3.
- R6: Register 5 reaches the data protection word when cache-select is 0 or 2, and the instruction protection word when cache-select is 1. Cache-select 3 is an error.
- R7: Register 9 reaches four separate words by cache-select: 0 data lockdown, 1 instruction lockdown, 2 data tightly-coupled-memory control, 3 instruction tightly-coupled-memory control.
- R8: Register 6 accesses one of eight region entries chosen by `acc_area`, whatever the cache-select. The fields are: enable in bit 0, size in bits [5:1], base in bits [31:12]. Bits [11:6] are not stored and read as 0.
- R9: A legal write to register 7 gives `mnt_valid`=1 for one cycle, in the same cycle as the ack. `mnt_op` = {cache-select[0], data[2:0]} and `mnt_addr` = the data with bits [2:0] cleared. Legal writes are cache-select 0 with data[2:0] from 0 to 5, and cache-select 1 with data[2:0] from 0 to 2.
- R10: Any other write to register 7 raises `acc_err` and issues no command.
- R11: A read of register 7 or of an unimplemented register number (4, 8, 10, 11, 12, 14, 15) returns 0 with `acc_err`. A write to an unimplemented number is an error and changes nothing. Whenever `acc_err` is 1, `acc_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_reg | input | 4 | Register number |
| acc_csel | input | 2 | Cache-select steering value |
| acc_area | input | 3 | Region entry index for register 6 |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid with the ack |
| acc_ack | output | 1 | Access completed |
| acc_err | output | 1 | Access refused |
| mnt_valid | output | 1 | Maintenance command pulse |
| mnt_op | output | 4 | Maintenance opcode |
| mnt_addr | output | 32 | Aligned maintenance address |

## Verification
The hardest case to reach is a physical bank shared by two cache-select values. Only a write through one alias followed by a read through the other shows that the aliases land on one word and not on separate words. The bench writes a distinct word to every register number under every cache-select. It then reads every pair back against a model keyed by physical bank, so each alias and each refused pair is crossed. The maintenance decoder is driven with all 32 combinations of cache-select and low data bits, which reaches every illegal opcode.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW = 32;

    typedef enum logic [3:0] {
        SL_CTRL, SL_DCC, SL_ICC, SL_BUF, SL_DPROT, SL_IPROT,
        SL_DLOCK, SL_ILOCK, SL_DTCM, SL_ITCM, SL_TRACE
    } slot_e;
    localparam int NSLOT = 11;

    typedef enum logic [2:0] {
        K_BAD, K_SLOT, K_IDENT, K_REGION, K_CMD
    } kind_e;

    typedef struct packed {
        kind_e kind;
        slot_e slot;
    } route_t;

    localparam logic [3:0] RN_IDENT  = 4'd0;
    localparam logic [3:0] RN_CTRL   = 4'd1;
    localparam logic [3:0] RN_CACHE  = 4'd2;
    localparam logic [3:0] RN_BUF    = 4'd3;
    localparam logic [3:0] RN_PROT   = 4'd5;
    localparam logic [3:0] RN_REGION = 4'd6;
    localparam logic [3:0] RN_CMD    = 4'd7;
    localparam logic [3:0] RN_LOCK   = 4'd9;
    localparam logic [3:0] RN_TRACE  = 4'd13;

    function automatic route_t route(input logic [3:0] rn, input logic [1:0] cs);
        route_t r;
        r.kind = K_BAD;
        r.slot = SL_CTRL;
        case (rn)
            RN_IDENT:  r.kind = (cs == 2'd3) ? K_BAD : K_IDENT;
            RN_CTRL:   begin r.kind = K_SLOT; r.slot = SL_CTRL;  end
            RN_BUF:    begin r.kind = K_SLOT; r.slot = SL_BUF;   end
            RN_TRACE:  begin r.kind = K_SLOT; r.slot = SL_TRACE; end
            RN_CACHE:  begin
                r.kind = K_SLOT;
                r.slot = cs[0] ? SL_ICC : SL_DCC;
            end
            RN_PROT:   begin
                if (cs != 2'd3) begin
                    r.kind = K_SLOT;
                    r.slot = (cs == 2'd1) ? SL_IPROT : SL_DPROT;
                end
            end
            RN_LOCK:   begin
                r.kind = K_SLOT;
                case (cs)
                    2'd0:    r.slot = SL_DLOCK;
                    2'd1:    r.slot = SL_ILOCK;
                    2'd2:    r.slot = SL_DTCM;
                    default: r.slot = SL_ITCM;
                endcase
            end
            RN_REGION: r.kind = K_REGION;
            RN_CMD:    r.kind = K_CMD;
            default:   r.kind = K_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sysctl_word_bank.sv
module sysctl_word_bank #(
    parameter int NWORDS = 11,
    parameter int W      = 32,
    parameter int IW     = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (wr_en && wr_idx == IW'(g))
                words[g] <= wr_data;
        end

        // R4/R5/R6/R7: a write reaches exactly the word it names
        p_word_store_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IW'(g)) |=> words[g] == $past(wr_data));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NWORDS; i++)
            if (rd_idx == IW'(i))
                rd_data = words[i];
    end

endmodule

// File: rtl/sysctl_region_table.sv
module sysctl_region_table #(
    parameter int NAREA    = 8,
    parameter int AW       = $clog2(NAREA),
    parameter int W        = 32,
    parameter int SZW      = 5,
    parameter int BASE_LSB = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data
);

    localparam int BW  = W - BASE_LSB;
    localparam int GAP = BASE_LSB - 1 - SZW;

    logic           en   [NAREA];
    logic [SZW-1:0] size [NAREA];
    logic [BW-1:0]  base [NAREA];

    for (genvar g = 0; g < NAREA; g++) begin : g_area
        always_ff @(posedge clk) begin
            if (rst) begin
                en[g]   <= 1'b0;
                size[g] <= '0;
                base[g] <= '0;
            end else if (wr_en && idx == AW'(g)) begin
                en[g]   <= wr_data[0];
                size[g] <= wr_data[SZW:1];
                base[g] <= wr_data[W-1:BASE_LSB];
            end
        end

        // R8: each entry takes the fields of a write addressed to it
        p_area_store_r8: assert property (@(posedge clk) disable iff (rst)
            (wr_en && idx == AW'(g)) |=>
                (en[g] == $past(wr_data[0]) && base[g] == $past(wr_data[W-1:BASE_LSB])));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NAREA; i++)
            if (idx == AW'(i))
                rd_data = {base[i], {GAP{1'b0}}, size[i], en[i]};
    end

endmodule

// File: rtl/sysctl_cmd_decode.sv
module sysctl_cmd_decode #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  logic [1:0]   csel,
    input  logic [W-1:0] wdata,
    output logic         legal,
    output logic         mnt_valid,
    output logic [3:0]   mnt_op,
    output logic [W-1:0] mnt_addr
);

    localparam logic [2:0] D_LAST = 3'd5;
    localparam logic [2:0] I_LAST = 3'd2;

    always_comb begin
        unique case (csel)
            2'd0:    legal = (wdata[2:0] <= D_LAST);
            2'd1:    legal = (wdata[2:0] <= I_LAST);
            default: legal = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mnt_valid <= 1'b0;
            mnt_op    <= '0;
            mnt_addr  <= '0;
        end else if (fire && legal) begin
            mnt_valid <= 1'b1;
            mnt_op    <= {csel[0], wdata[2:0]};
            mnt_addr  <= {wdata[W-1:3], 3'b000};
        end else begin
            mnt_valid <= 1'b0;
            mnt_op    <= '0;
            mnt_addr  <= '0;
        end
    end

    // R9: a command only follows a write to the command register
    p_cmd_from_fire_r9: assert property (@(posedge clk) disable iff (rst)
        mnt_valid |-> $past(fire));

    // R10: an illegal combination never produces a command
    p_cmd_illegal_r10: assert property (@(posedge clk) disable iff (rst)
        (fire && !legal) |=> !mnt_valid);

endmodule

// File: rtl/sysctl_access_fsm.sv
module sysctl_access_fsm (
    input  logic clk,
    input  logic rst,
    input  logic req_rd,
    input  logic req_wr,
    input  logic bad,
    output logic ack,
    output logic err
);

    typedef enum logic [1:0] {ST_IDLE, ST_DONE, ST_FAULT} state_e;

    state_e state, state_nx;

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (req_rd || req_wr)
                    state_nx = bad ? ST_FAULT : ST_DONE;
                else
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        ack = 1'b0;
        err = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_DONE:  ack = 1'b1;
            ST_FAULT: begin ack = 1'b1; err = 1'b1; end
            default:  ;
        endcase
    end

    // R3: an ack answers a request of the previous cycle
    p_ack_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(req_rd || req_wr));

    // R3: no ack without a request
    p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !(req_rd || req_wr) |=> !ack);

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_WORD   = 32'h5A01_0C31,
    parameter logic [31:0] CACHE_CFG = 32'h0F0A_2B3C,
    parameter logic [31:0] TCM_INFO  = 32'h0003_0C00,
    parameter int          NAREA     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_rd,
    input  logic        acc_wr,
    input  logic [3:0]  acc_reg,
    input  logic [1:0]  acc_csel,
    input  logic [2:0]  acc_area,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_ack,
    output logic        acc_err,
    output logic        mnt_valid,
    output logic [3:0]  mnt_op,
    output logic [31:0] mnt_addr
);

    localparam int SW = $clog2(NSLOT);

    route_t      rt;
    logic        both, cmd_legal, bad, go_rd, go_wr;
    logic [DW-1:0] bank_rd, area_rd, rd_mux;

    assign rt   = route(acc_reg, acc_csel);
    assign both = acc_rd && acc_wr;

    always_comb begin
        bad = both || (rt.kind == K_BAD);
        if (acc_rd && rt.kind == K_CMD)
            bad = 1'b1;
        if (acc_wr && rt.kind == K_IDENT)
            bad = 1'b1;
        if (acc_wr && rt.kind == K_CMD && !cmd_legal)
            bad = 1'b1;
    end

    assign go_rd = acc_rd && !acc_wr && !bad;
    assign go_wr = acc_wr && !acc_rd && !bad;

    sysctl_access_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .req_rd (acc_rd),
        .req_wr (acc_wr),
        .bad    (bad),
        .ack    (acc_ack),
        .err    (acc_err)
    );

    sysctl_word_bank #(.NWORDS(NSLOT), .W(DW), .IW(SW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (go_wr && rt.kind == K_SLOT),
        .wr_idx  (SW'(rt.slot)),
        .wr_data (acc_wdata),
        .rd_idx  (SW'(rt.slot)),
        .rd_data (bank_rd)
    );

    sysctl_region_table #(.NAREA(NAREA), .AW(3), .W(DW)) u_area (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (go_wr && rt.kind == K_REGION),
        .idx     (acc_area),
        .wr_data (acc_wdata),
        .rd_data (area_rd)
    );

    sysctl_cmd_decode #(.W(DW)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .fire      (acc_wr && !acc_rd && rt.kind == K_CMD),
        .csel      (acc_csel),
        .wdata     (acc_wdata),
        .legal     (cmd_legal),
        .mnt_valid (mnt_valid),
        .mnt_op    (mnt_op),
        .mnt_addr  (mnt_addr)
    );

    always_comb begin
        rd_mux = '0;
        case (rt.kind)
            K_IDENT: begin
                case (acc_csel)
                    2'd0:    rd_mux = ID_WORD;
                    2'd1:    rd_mux = CACHE_CFG;
                    default: rd_mux = TCM_INFO;
                endcase
            end
            K_SLOT:   rd_mux = bank_rd;
            K_REGION: rd_mux = area_rd;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_rdata <= '0;
        else if (go_rd)
            acc_rdata <= rd_mux;
        else
            acc_rdata <= '0;
    end

    // R11: a refused access never returns data
    p_err_zero_data_r11: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> acc_rdata == '0);

    // R10: a command and a refusal never coincide
    p_cmd_no_err_r10: assert property (@(posedge clk) disable iff (rst)
        mnt_valid |-> (acc_ack && !acc_err));

    // R2: writes to the identification register are refused
    p_ident_ro_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_reg == RN_IDENT) |=> acc_err);

endmodule

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;

    localparam logic [31:0] P_ID  = 32'h5A01_0C31;
    localparam logic [31:0] P_CFG = 32'h0F0A_2B3C;
    localparam logic [31:0] P_TCM = 32'h0003_0C00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_rd = 1'b0, acc_wr = 1'b0;
    logic [3:0]  acc_reg = '0;
    logic [1:0]  acc_csel = '0;
    logic [2:0]  acc_area = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_ack, acc_err, mnt_valid;
    logic [3:0]  mnt_op;
    logic [31:0] mnt_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_bank [11];
    logic [31:0] m_area [8];
    logic [31:0] s_rdata, s_maddr;
    logic        s_ack, s_err, s_mv;
    logic [3:0]  s_mop;

    always #2 clk = ~clk;

    sysctl_regbank dut (
        .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_reg(acc_reg), .acc_csel(acc_csel), .acc_area(acc_area),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_ack(acc_ack),
        .acc_err(acc_err), .mnt_valid(mnt_valid), .mnt_op(mnt_op),
        .mnt_addr(mnt_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // physical bank per register and cache-select, -1 when none
    function automatic int bank_of(input int rn, input int cs);
        case (rn)
            1:  return 0;
            3:  return 1;
            13: return 2;
            2:  return (cs % 2 == 1) ? 4 : 3;
            5:  return (cs == 3) ? -1 : ((cs == 1) ? 6 : 5);
            9:  return 7 + cs;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] ident(input int cs);
        return (cs == 0) ? P_ID : (cs == 1) ? P_CFG : P_TCM;
    endfunction

    task automatic access(input bit rd, input bit wr, input int rn, input int cs,
                          input int ar, input logic [31:0] wd);
        @(negedge clk);
        acc_rd = rd; acc_wr = wr;
        acc_reg = 4'(rn); acc_csel = 2'(cs); acc_area = 3'(ar); acc_wdata = wd;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0;
        s_rdata = acc_rdata; s_ack = acc_ack; s_err = acc_err;
        s_mv = mnt_valid; s_mop = mnt_op; s_maddr = mnt_addr;
    endtask

    task automatic read_check(input int rn, input int cs, input int ar);
        logic [31:0] e;
        bit ee;
        int b;
        b = bank_of(rn, cs);
        if (rn == 0) begin
            ee = (cs == 3); e = ee ? 32'h0 : ident(cs);
        end else if (rn == 6) begin
            ee = 1'b0; e = m_area[ar];
        end else if (b >= 0) begin
            ee = 1'b0; e = m_bank[b];
        end else begin
            ee = 1'b1; e = 32'h0;
        end
        access(1'b1, 1'b0, rn, cs, ar, 32'h0);
        // R2 R4 R5 R6 R7 R8 R11 read path
        chk(s_rdata === e, $sformatf("R2/R4-R8/R11 rdata reg%0d sel%0d", rn, cs), s_rdata, e);
        chk(s_err === ee && s_ack === 1'b1, "R3 R11 ack/err on read",
            {30'h0, s_ack, s_err}, {30'h0, 1'b1, ee});
    endtask

    initial begin
        for (int i = 0; i < 11; i++) m_bank[i] = '0;
        for (int i = 0; i < 8; i++)  m_area[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 idle outputs after reset
        chk(acc_ack === 1'b0 && acc_err === 1'b0 && mnt_valid === 1'b0,
            "R1 idle after reset", {29'h0, acc_ack, acc_err, mnt_valid}, 32'h0);

        // R1 R2 R11: sweep reads on fresh state
        for (int rn = 0; rn < 16; rn++)
            for (int cs = 0; cs < 4; cs++)
                read_check(rn, cs, cs);

        // R4 R5 R6 R7 R2 R11: write every register/select pair except commands
        for (int rn = 0; rn < 16; rn++) begin
            for (int cs = 0; cs < 4; cs++) begin
                logic [31:0] d;
                int b;
                bit ee;
                if (rn == 7) continue;
                d = 32'hC300_0000 ^ 32'(rn << 16) ^ 32'(cs << 8) ^ 32'(rn * 37 + cs * 11);
                b = bank_of(rn, cs);
                ee = !(rn == 6 || b >= 0);
                access(1'b0, 1'b1, rn, cs, cs * 2 + 1, d);
                if (rn == 6) m_area[cs * 2 + 1] = d & 32'hFFFF_F03F;
                else if (b >= 0) m_bank[b] = d;
                chk(s_err === ee && s_ack === 1'b1, "R2/R11 write ack/err",
                    {30'h0, s_ack, s_err}, {30'h0, 1'b1, ee});
            end
        end
        for (int rn = 0; rn < 16; rn++)
            for (int cs = 0; cs < 4; cs++)
                read_check(rn, cs, cs * 2 + 1);

        // R8: every region entry with its own pattern
        for (int a = 0; a < 8; a++) begin
            logic [31:0] d;
            d = 32'h1357_9BDF ^ 32'(a * 32'h1111_1111);
            access(1'b0, 1'b1, 6, a % 4, a, d);
            m_area[a] = d & 32'hFFFF_F03F;
        end
        for (int a = 0; a < 8; a++)
            read_check(6, 3 - (a % 4), a);

        // R9 R10: all select and low-bit combinations on the command register
        for (int cs = 0; cs < 4; cs++) begin
            for (int op = 0; op < 8; op++) begin
                logic [31:0] d;
                bit lg;
                d = 32'h8000_0000 | 32'(cs << 20) | 32'(op << 3) | 32'(op);
                lg = (cs == 0 && op <= 5) || (cs == 1 && op <= 2);
                access(1'b0, 1'b1, 7, cs, 0, d);
                chk(s_mv === lg, "R9/R10 command pulse", {31'h0, s_mv}, {31'h0, lg});
                chk(s_err === !lg, "R10 error flag", {31'h0, s_err}, {31'h0, !lg});
                if (lg) begin
                    chk(s_mop === {cs[0], 3'(op)}, "R9 opcode", {28'h0, s_mop}, {28'h0, cs[0], 3'(op)});
                    chk(s_maddr === (d & 32'hFFFF_FFF8), "R9 address", s_maddr, d & 32'hFFFF_FFF8);
                end
                @(negedge clk);
                chk(mnt_valid === 1'b0, "R9 single-cycle pulse", {31'h0, mnt_valid}, 32'h0);
            end
        end
        // R9 worked example: 0x80000002 with select 1 -> prefetch at 0x80000000
        access(1'b0, 1'b1, 7, 1, 0, 32'h8000_0002);
        chk(s_mop === 4'hA && s_maddr === 32'h8000_0000, "R9 prefetch example",
            s_maddr, 32'h8000_0000);

        // R3: both strobes together are refused and change nothing
        access(1'b1, 1'b1, 1, 0, 0, 32'hDEAD_BEEF);
        chk(s_err === 1'b1 && s_rdata === 32'h0, "R3 both strobes", {31'h0, s_err}, 32'h1);
        read_check(1, 2, 0);

        // R1: reset clears everything again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 11; i++) m_bank[i] = '0;
        for (int i = 0; i < 8; i++)  m_area[i] = '0;
        read_check(9, 3, 0);
        read_check(6, 0, 5);
        read_check(13, 1, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule